// File: doc/BRIEF.md
# Programmable sum-of-products array

This block is the logic plane of a small programmable-logic fabric. A bank of input signals is turned into a literal vector that carries each signal in both true and inverted form. A fuse matrix then picks which literals feed each product term. The product terms are gathered in fixed groups, and each output ORs its own group. The fuse matrix is a static configuration word that sits on an input port. The surrounding logic holds it and never changes it during operation.

Two rules fix the value of degenerate terms. A term with no literal connected reads as 1. A term that connects both forms of the same signal reads as 0. The first term of every group is also brought out on its own output, so that a following output stage can use it as an enable. A per-output mask takes that first term out of the OR sum. Both results are registered once, so outputs follow inputs with one clock of latency.

Top module: `sop_array`

## Requirements
- R1: Signal k drives literal column 2k in true form and column 2k+1 in inverted form. Fuse bit `fuse_i[t*40 + c]` set to 1 connects column c to product term t (40 columns, 64 terms by default).
- R2: A product term is the AND of every literal connected to it.
- R3: A product term with no connected literal evaluates to 1.
- R4: A product term that connects both the true and the inverted column of the same signal evaluates to 0 for every input value.
- R5: Output o ORs product terms 8o through 8o+7, and no other terms.
- R6: When `lead_mask_i[o]` is 1, term 8o is left out of the OR of output o. When it is 0, that term takes part.
- R7: `lead_o[o]` equals term 8o whatever the mask holds.
- R8: `sum_o` and `lead_o` show the result for the inputs present at the previous rising clock edge. An active-low asynchronous reset clears both to 0.
- R9: For an unmasked output, `lead_o[o]` = 1 implies `sum_o[o]` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous reset, active low |
| sig_i | input | 20 | Input signals, before literal expansion |
| fuse_i | input | 2560 | Static fuse matrix, term-major, 1 = connected |
| lead_mask_i | input | 8 | Per-output removal of the first group term from the sum |
| sum_o | output | 8 | Registered OR sum of each group |
| lead_o | output | 8 | Registered first term of each group |

## Verification
The hard case is a single product term deciding an output on its own, because the seven other terms of the group usually mask it. The bench solves this by building fuse maps in which every other term is made contradictory, so it reads 0. Then one chosen term, with a known set of literals, controls the output. Random sparse maps, with some rows forced empty and some forced contradictory, are compared against an independent per-signal model for the general case.

// File: rtl/sop_array_pkg.sv
package sop_array_pkg;

    localparam int unsigned SIGS_DEF      = 20;
    localparam int unsigned OUTS_DEF      = 8;
    localparam int unsigned TERMS_PER_DEF = 8;

    // column index of a signal's literal; inverted form sits one above the true form
    function automatic int unsigned lit_col(input int unsigned sig, input bit inverted);
        return 2 * sig + (inverted ? 1 : 0);
    endfunction

endpackage

// File: rtl/sop_literal_gen.sv
module sop_literal_gen #(
    parameter int unsigned N_SIG = 20,
    localparam int unsigned N_LIT = 2 * N_SIG
) (
    input  logic [N_SIG-1:0] sig_i,
    output logic [N_LIT-1:0] lit_o
);
    import sop_array_pkg::*;

    for (genvar k = 0; k < N_SIG; k++) begin : g_sig
        assign lit_o[lit_col(k, 1'b0)] = sig_i[k];
        assign lit_o[lit_col(k, 1'b1)] = ~sig_i[k];
    end

endmodule

// File: rtl/sop_term_plane.sv
module sop_term_plane #(
    parameter int unsigned N_LIT  = 40,
    parameter int unsigned N_TERM = 64
) (
    input  logic [N_LIT-1:0]        lit_i,
    input  logic [N_TERM*N_LIT-1:0] fuse_i,
    output logic [N_TERM-1:0]       term_o
);

    // an unconnected column is forced to 1, so a row with no fuse set yields 1
    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        assign term_o[t] = &(~fuse_i[t*N_LIT +: N_LIT] | lit_i);
    end

endmodule

// File: rtl/sop_or_plane.sv
module sop_or_plane #(
    parameter int unsigned N_OUT = 8,
    parameter int unsigned GRP   = 8,
    localparam int unsigned N_TERM = N_OUT * GRP
) (
    input  logic [N_TERM-1:0] term_i,
    input  logic [N_OUT-1:0]  mask_i,
    output logic [N_OUT-1:0]  sum_o,
    output logic [N_OUT-1:0]  lead_o
);

    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        logic [GRP-1:0] grp;
        logic [GRP-1:0] keep;
        assign grp      = term_i[o*GRP +: GRP];
        assign keep     = grp & ~{{(GRP-1){1'b0}}, mask_i[o]};
        assign sum_o[o]  = |keep;
        assign lead_o[o] = grp[0];
    end

endmodule

// File: rtl/sop_array.sv
module sop_array #(
    parameter int unsigned N_SIG     = sop_array_pkg::SIGS_DEF,
    parameter int unsigned N_OUT     = sop_array_pkg::OUTS_DEF,
    parameter int unsigned TERMS_PER = sop_array_pkg::TERMS_PER_DEF,
    localparam int unsigned N_LIT    = 2 * N_SIG,
    localparam int unsigned N_TERM   = N_OUT * TERMS_PER,
    localparam int unsigned N_FUSE   = N_TERM * N_LIT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SIG-1:0]  sig_i,
    input  logic [N_FUSE-1:0] fuse_i,
    input  logic [N_OUT-1:0]  lead_mask_i,
    output logic [N_OUT-1:0]  sum_o,
    output logic [N_OUT-1:0]  lead_o
);

    typedef struct packed {
        logic [N_OUT-1:0] sum;
        logic [N_OUT-1:0] lead;
    } state_t;

    logic [N_LIT-1:0]  lit_w;
    logic [N_TERM-1:0] term_w;
    logic [N_OUT-1:0]  sum_w;
    logic [N_OUT-1:0]  lead_w;
    state_t st_d, st_q;

    sop_literal_gen #(.N_SIG(N_SIG)) lit_i (
        .sig_i (sig_i),
        .lit_o (lit_w)
    );

    sop_term_plane #(.N_LIT(N_LIT), .N_TERM(N_TERM)) and_i (
        .lit_i  (lit_w),
        .fuse_i (fuse_i),
        .term_o (term_w)
    );

    sop_or_plane #(.N_OUT(N_OUT), .GRP(TERMS_PER)) or_i (
        .term_i (term_w),
        .mask_i (lead_mask_i),
        .sum_o  (sum_w),
        .lead_o (lead_w)
    );

    always_comb begin
        st_d      = st_q;
        st_d.sum  = sum_w;
        st_d.lead = lead_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sum_o  = st_q.sum;
    assign lead_o = st_q.lead;

endmodule

// File: rtl/sop_array_chk.sv
module sop_array_chk #(
    parameter int unsigned N_SIG  = 20,
    parameter int unsigned N_OUT  = 8,
    parameter int unsigned N_FUSE = 2560
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_SIG-1:0]  sig_i,
    input logic [N_FUSE-1:0] fuse_i,
    input logic [N_OUT-1:0]  lead_mask_i,
    input logic [N_OUT-1:0]  sum_o,
    input logic [N_OUT-1:0]  lead_o
);

    assert_reset_clear_R8: assert property (@(posedge clk)
        !rst_n |=> (sum_o == '0 && lead_o == '0));

    assert_empty_map_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fuse_i == '0) |=> (sum_o == '1 && lead_o == '1));

    assert_full_map_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fuse_i == '1) |=> (sum_o == '0 && lead_o == '0));

    assert_hold_on_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $stable(sig_i) && $stable(fuse_i) && $stable(lead_mask_i))
        |=> ($stable(sum_o) && $stable(lead_o)));

    for (genvar o = 0; o < N_OUT; o++) begin : g_chk
        assert_lead_in_sum_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !lead_mask_i[o] |=> (!lead_o[o] || sum_o[o]));
    end

endmodule

bind sop_array sop_array_chk #(
    .N_SIG  (N_SIG),
    .N_OUT  (N_OUT),
    .N_FUSE (N_FUSE)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .sig_i       (sig_i),
    .fuse_i      (fuse_i),
    .lead_mask_i (lead_mask_i),
    .sum_o       (sum_o),
    .lead_o      (lead_o)
);

// File: tb/sop_array_tb_top.sv
module sop_array_tb_top;

    localparam int NS = 20;
    localparam int NL = 40;
    localparam int NO = 8;
    localparam int NT = 64;
    localparam int NF = NT * NL;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] sig = '0;
    logic [NF-1:0] fuse = '0;
    logic [NO-1:0] mask = '0;
    logic [NO-1:0] sum_o;
    logic [NO-1:0] lead_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    sop_array dut_i (
        .clk (clk), .rst_n (rst_n), .sig_i (sig), .fuse_i (fuse),
        .lead_mask_i (mask), .sum_o (sum_o), .lead_o (lead_o)
    );

    // stimulus table: {mask, signals}
    localparam logic [27:0] VEC [8] = '{
        {8'h00, 20'h00000}, {8'h00, 20'hFFFFF}, {8'h00, 20'hA5A5A}, {8'hFF, 20'h5A5A5},
        {8'h0F, 20'h12345}, {8'hF0, 20'hEDCBA}, {8'h3C, 20'h0F0F0}, {8'h81, 20'hF0F0F}
    };

    // independent model: a term dies when a connected literal is false
    function automatic logic [15:0] model(input logic [NS-1:0] s, input logic [NO-1:0] m,
                                          input logic [NF-1:0] f);
        logic [NO-1:0] sm = '0;
        logic [NO-1:0] ld = '0;
        for (int t = 0; t < NT; t++) begin
            bit alive = 1'b1;
            for (int k = 0; k < NS; k++) begin
                if (f[t*NL + 2*k]     && !s[k]) alive = 1'b0;
                if (f[t*NL + 2*k + 1] &&  s[k]) alive = 1'b0;
            end
            if (t % 8 == 0) ld[t/8] = alive;
            if (alive && !(t % 8 == 0 && m[t/8])) sm[t/8] = 1'b1;
        end
        return {ld, sm};
    endfunction

    task automatic chk(input string req, input logic [NO-1:0] act, input logic [NO-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply_check(input logic [NS-1:0] s, input logic [NO-1:0] m,
                               input string rs, input string rl);
        logic [15:0] e;
        @(negedge clk);
        sig = s; mask = m;
        @(negedge clk);
        e = model(s, m, fuse);
        chk(rs, sum_o, e[7:0]);
        chk(rl, lead_o, e[15:8]);
    endtask

    // every term contradictory on signal 0
    function automatic logic [NF-1:0] all_dead();
        logic [NF-1:0] f = '0;
        for (int t = 0; t < NT; t++) begin
            f[t*NL] = 1'b1; f[t*NL + 1] = 1'b1;
        end
        return f;
    endfunction

    initial begin
        logic [NF-1:0] f;
        logic [15:0]   e;
        // reset state R8
        sig = 20'h3C3C3; mask = 8'h55;
        #35;
        chk("R8 reset sum", sum_o, '0);
        chk("R8 reset lead", lead_o, '0);
        @(negedge clk); rst_n = 1'b1;

        // table walk over a computed map (R2, R5, R6, R7)
        f = '0;
        for (int t = 0; t < NT; t++) begin
            f[t*NL + 2*(t % NS) + (t % 2)] = 1'b1;
            f[t*NL + 2*((t*7) % NS)]       = 1'b1;
        end
        fuse = f;
        foreach (VEC[i]) apply_check(VEC[i][19:0], VEC[i][27:20], "R5 table sum", "R7 table lead");

        // empty map R3
        fuse = '0;
        apply_check(20'h12345, 8'h00, "R3 empty sum", "R3 empty lead");
        apply_check(20'h54321, 8'hFF, "R3 empty masked sum", "R3 empty masked lead");
        chk("R3 empty direct", sum_o, 8'hFF);

        // contradictory map R4
        fuse = all_dead();
        apply_check(20'h00000, 8'h00, "R4 dead sum", "R4 dead lead");
        chk("R4 dead direct", sum_o, 8'h00);
        apply_check(20'hFFFFF, 8'h00, "R4 dead sum ones", "R4 dead lead ones");

        // R6: only the lead term of each group is live (empty)
        f = all_dead();
        for (int o = 0; o < NO; o++) begin
            f[o*8*NL] = 1'b0; f[o*8*NL + 1] = 1'b0;
        end
        fuse = f;
        apply_check(20'h0, 8'hA5, "R6 mask sum", "R7 mask lead");
        chk("R6 mask direct", sum_o, 8'h5A);
        chk("R7 lead ignores mask", lead_o, 8'hFF);

        // R1: term 0 connects only column 3 (signal 1 inverted)
        f = all_dead();
        f[0] = 1'b0; f[1] = 1'b0; f[3] = 1'b1;
        fuse = f;
        apply_check(20'h00000, 8'h00, "R1 col3 sum", "R1 col3 lead");
        chk("R1 col3 sig1=0", lead_o[0], 1'b1);
        apply_check(20'h00002, 8'h00, "R1 col3 sum b", "R1 col3 lead b");
        chk("R1 col3 sig1=1", lead_o[0], 1'b0);

        // R2: term 9 = sig2 & sig5
        f = all_dead();
        f[9*NL] = 1'b0; f[9*NL + 1] = 1'b0;
        f[9*NL + 4] = 1'b1; f[9*NL + 10] = 1'b1;
        fuse = f;
        for (int v = 0; v < 4; v++) begin
            logic [NS-1:0] s = '0;
            s[2] = v[0]; s[5] = v[1];
            apply_check(s, 8'h00, "R2 and sum", "R2 and lead");
            chk("R2 and direct", sum_o[1], (v == 3) ? 1'b1 : 1'b0);
        end

        // random sparse maps with forced empty and contradictory rows (R5, R9)
        for (int it = 0; it < 150; it++) begin
            f = '0;
            for (int b = 0; b < NF; b++) f[b] = ($urandom_range(15) == 0);
            f[($urandom_range(NT-1))*NL +: NL] = '0;
            begin
                int r = $urandom_range(NT-1);
                int k = $urandom_range(NS-1);
                f[r*NL + 2*k] = 1'b1; f[r*NL + 2*k + 1] = 1'b1;
            end
            fuse = f;
            apply_check($urandom, $urandom, "R5 random sum", "R7 random lead");
            for (int o = 0; o < NO; o++)
                if (!mask[o] && lead_o[o]) chk("R9 lead in sum", sum_o[o], 1'b1);
        end

        // R8 latency and mid-run reset
        fuse = '0;
        apply_check(20'h0, 8'h00, "R8 pre sum", "R8 pre lead");
        @(negedge clk);
        fuse = all_dead();
        #1;
        chk("R8 holds before edge", sum_o, 8'hFF);
        @(negedge clk);
        chk("R8 after edge", sum_o, 8'h00);
        fuse = '0;
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R8 async clear", sum_o, 8'h00);
        chk("R8 async clear lead", lead_o, 8'h00);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        e = model(sig, mask, fuse);
        chk("R8 after reset", sum_o, e[7:0]);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule